// File: doc/BRIEF.md
# Clock Replacement Victim Selector

This block chooses which physical page frame to evict when a new page must come into memory. It uses the second-chance (clock) policy. For every frame it keeps three bits: a reference bit, a dirty bit and an occupied bit. Memory accesses reported on the access port set the reference bit of the touched frame, and a write access also sets its dirty bit. Loading a page into a frame marks the frame occupied, sets its reference bit and clears its dirty bit.

A victim request starts a scan. If any frame is still unoccupied, the lowest-numbered free frame is returned at once and the hand does not move. Otherwise a rotating hand walks the frames in circular order, one frame per clock. Each frame it finds with the reference bit set loses that bit and is passed over. The first frame with a clear reference bit becomes the victim. The hand then rests on the frame after the victim, ready for the next request.

The result comes with a flag that says whether the frame holds modified data and so must be written back before reuse. Moving the page to and from the backing store, and updating the page tables, are left to the surrounding system.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset, all frames are unoccupied, the hand points at frame 0, and `busy` and `done` are low.
- R2: If any frame is unoccupied when the scan evaluates, the result is the lowest-numbered unoccupied frame, with `victim_free`=1 and `victim_dirty`=0, one cycle after the request is taken. The hand does not move.
- R3: An access sets the reference bit of `acc_frame`. When `acc_write`=1 it also sets that frame's dirty bit.
- R4: A fill of a frame sets its occupied bit and its reference bit and clears its dirty bit. A write access to the same frame in the same cycle still sets the dirty bit.
- R5: With every frame occupied, the scan examines frames in circular order, starting at the hand and one frame per clock cycle. A frame whose reference bit is 1 has that bit cleared and is skipped.
- R6: The first frame examined with a reference bit of 0 becomes the victim, with `victim_free`=0.
- R7: `victim_dirty` equals the victim's dirty bit at the moment of selection. It is always 0 for a free frame.
- R8: After a victim is chosen from occupied frames, the hand moves to the victim index plus one, wrapping from NFRAMES-1 back to 0.
- R9: A scan examines at most NFRAMES+1 frames. When every reference bit is set, it examines exactly NFRAMES+1 and returns the frame at which it started.
- R10: An access that arrives in the same cycle the scan clears that frame's reference bit wins, and the bit stays 1.
- R11: A request is taken only while `busy` is low. `busy` stays high from the cycle after acceptance until the result is ready. `done` is high for exactly one cycle, and the result ports hold their values until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access to a frame occurs this cycle |
| acc_frame | input | IDX_W | Frame index of the access |
| acc_write | input | 1 | The access is a write |
| fill_valid | input | 1 | A new page is loaded into a frame this cycle |
| fill_frame | input | IDX_W | Frame index being loaded |
| req | input | 1 | Request a victim frame |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle pulse: the result is valid |
| victim | output | IDX_W | Chosen frame index |
| victim_dirty | output | 1 | The chosen frame must be written back first |
| victim_free | output | 1 | The chosen frame was unoccupied |

## Verification
The bench builds the block with NFRAMES=6. With six frames, the hand must wrap from index 5 to 0, which a power-of-two size would never exercise. A full rotation with every reference bit set takes only seven scan cycles, so the worst-case scan length and the clear-and-skip path come up often in random traffic. A directed access timed to the cycle in which the scan clears that same frame checks the collision rule.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/cvs_frame_bits.sv
module cvs_frame_bits #(
  parameter int NFRAMES = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [IDX_W-1:0]   acc_frame,
  input  logic               acc_write,
  input  logic               fill_valid,
  input  logic [IDX_W-1:0]   fill_frame,
  input  logic               clr_valid,
  input  logic [IDX_W-1:0]   clr_frame,
  output logic [NFRAMES-1:0] ref_vec,
  output logic [NFRAMES-1:0] dirty_vec,
  output logic [NFRAMES-1:0] occ_vec
);

  for (genvar f = 0; f < NFRAMES; f++) begin : g_frame
    logic hit_acc, hit_fill, hit_clr, upd_en;
    logic ref_q, ref_d, dirty_q, dirty_d, occ_q, occ_d;

    assign hit_acc  = acc_valid  && (acc_frame  == IDX_W'(f));
    assign hit_fill = fill_valid && (fill_frame == IDX_W'(f));
    assign hit_clr  = clr_valid  && (clr_frame  == IDX_W'(f));
    assign upd_en   = hit_acc || hit_fill || hit_clr;

    // The scan clear comes first, so an access or a fill in the same cycle wins.
    always_comb begin
      ref_d   = ref_q;
      dirty_d = dirty_q;
      occ_d   = occ_q;
      if (hit_clr)              ref_d   = 1'b0;
      if (hit_fill || hit_acc)  ref_d   = 1'b1;
      if (hit_fill)             dirty_d = 1'b0;
      if (hit_acc && acc_write) dirty_d = 1'b1;
      if (hit_fill)             occ_d   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q   <= 1'b0;
        dirty_q <= 1'b0;
        occ_q   <= 1'b0;
      end else if (upd_en) begin
        ref_q   <= ref_d;
        dirty_q <= dirty_d;
        occ_q   <= occ_d;
      end
    end

    assign ref_vec[f]   = ref_q;
    assign dirty_vec[f] = dirty_q;
    assign occ_vec[f]   = occ_q;
  end

endmodule

// File: rtl/cvs_free_pick.sv
module cvs_free_pick #(
  parameter int NFRAMES = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NFRAMES-1:0] occ_vec,
  output logic               any_free,
  output logic [IDX_W-1:0]   free_idx
);

  // Walk downward so the lowest free index is the last one written.
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = NFRAMES - 1; i >= 0; i--) begin
      if (!occ_vec[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/cvs_hand_seq.sv
module cvs_hand_seq
  import cvs_pkg::*;
#(
  parameter int NFRAMES = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               any_free,
  input  logic [IDX_W-1:0]   free_idx,
  input  logic [NFRAMES-1:0] ref_vec,
  input  logic [NFRAMES-1:0] dirty_vec,
  output logic               busy,
  output logic               done,
  output logic [IDX_W-1:0]   victim,
  output logic               victim_dirty,
  output logic               victim_free,
  output logic [IDX_W-1:0]   hand,
  output logic               clr_valid,
  output logic [IDX_W-1:0]   clr_frame
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NFRAMES - 1);

  scan_state_e      st_q, st_d;
  logic [IDX_W-1:0] hand_q, hand_d, hand_nxt;
  logic             done_q, done_d;
  logic [IDX_W-1:0] vic_q, vic_d;
  logic             vdirty_q, vdirty_d, vfree_q, vfree_d;

  assign hand_nxt = (hand_q == LAST_IDX) ? '0 : hand_q + 1'b1;

  always_comb begin
    st_d      = st_q;
    hand_d    = hand_q;
    done_d    = 1'b0;
    vic_d     = vic_q;
    vdirty_d  = vdirty_q;
    vfree_d   = vfree_q;
    clr_valid = 1'b0;
    unique case (st_q)
      SCAN_IDLE: begin
        if (req) st_d = SCAN_RUN;
      end
      SCAN_RUN: begin
        if (any_free) begin
          done_d   = 1'b1;
          vic_d    = free_idx;
          vdirty_d = 1'b0;
          vfree_d  = 1'b1;
          st_d     = SCAN_IDLE;
        end else if (!ref_vec[hand_q]) begin
          done_d   = 1'b1;
          vic_d    = hand_q;
          vdirty_d = dirty_vec[hand_q];
          vfree_d  = 1'b0;
          hand_d   = hand_nxt;
          st_d     = SCAN_IDLE;
        end else begin
          clr_valid = 1'b1;
          hand_d    = hand_nxt;
        end
      end
      default: st_d = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SCAN_IDLE;
      hand_q   <= '0;
      done_q   <= 1'b0;
      vic_q    <= '0;
      vdirty_q <= 1'b0;
      vfree_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      hand_q <= hand_d;
      done_q <= done_d;
      if (done_d) begin
        vic_q    <= vic_d;
        vdirty_q <= vdirty_d;
        vfree_q  <= vfree_d;
      end
    end
  end

  assign busy         = (st_q == SCAN_RUN);
  assign done         = done_q;
  assign victim       = vic_q;
  assign victim_dirty = vdirty_q;
  assign victim_free  = vfree_q;
  assign hand         = hand_q;
  assign clr_frame    = hand_q;

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NFRAMES = 8,
  parameter int IDX_W   = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_frame,
  input  logic             acc_write,
  input  logic             fill_valid,
  input  logic [IDX_W-1:0] fill_frame,
  input  logic             req,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] victim,
  output logic             victim_dirty,
  output logic             victim_free
);

  logic [1:0]         rst_pipe;
  logic               core_rst_n;
  logic [NFRAMES-1:0] ref_vec, dirty_vec, occ_vec;
  logic               any_free, clr_valid;
  logic [IDX_W-1:0]   free_idx, clr_frame, hand;

  // Reset asserts at once and is released two clock edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  cvs_frame_bits #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_bits (
    .clk(clk), .rst_n(core_rst_n),
    .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
    .fill_valid(fill_valid), .fill_frame(fill_frame),
    .clr_valid(clr_valid), .clr_frame(clr_frame),
    .ref_vec(ref_vec), .dirty_vec(dirty_vec), .occ_vec(occ_vec)
  );

  cvs_free_pick #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_free (
    .occ_vec(occ_vec), .any_free(any_free), .free_idx(free_idx)
  );

  cvs_hand_seq #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(core_rst_n), .req(req),
    .any_free(any_free), .free_idx(free_idx),
    .ref_vec(ref_vec), .dirty_vec(dirty_vec),
    .busy(busy), .done(done), .victim(victim),
    .victim_dirty(victim_dirty), .victim_free(victim_free),
    .hand(hand), .clr_valid(clr_valid), .clr_frame(clr_frame)
  );

endmodule

// File: rtl/clock_victim_chk.sv
module clock_victim_chk #(
  parameter int NFRAMES = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic [IDX_W-1:0]   acc_frame,
  input logic               acc_write,
  input logic               fill_valid,
  input logic [IDX_W-1:0]   fill_frame,
  input logic               busy,
  input logic               done,
  input logic [IDX_W-1:0]   victim,
  input logic               victim_dirty,
  input logic               victim_free,
  input logic [IDX_W-1:0]   hand,
  input logic [NFRAMES-1:0] ref_vec,
  input logic [NFRAMES-1:0] dirty_vec,
  input logic [NFRAMES-1:0] occ_vec
);

  localparam int CW = $clog2(NFRAMES + 3) + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NFRAMES - 1);

  logic [CW-1:0] scan_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    scan_cnt <= '0;
    else if (busy) scan_cnt <= scan_cnt + 1'b1;
    else           scan_cnt <= '0;
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_scan_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scan_cnt <= CW'(NFRAMES + 1));
  assert_free_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && victim_free) |-> !victim_dirty);
  assert_hand_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !victim_free) |-> (hand == ((victim == LAST_IDX) ? '0 : victim + 1'b1)));
  assert_acc_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_frame <= LAST_IDX)) |=> ref_vec[$past(acc_frame)]);
  assert_acc_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && (acc_frame <= LAST_IDX)) |=> dirty_vec[$past(acc_frame)]);
  assert_fill_occ_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && (fill_frame <= LAST_IDX)) |=> (occ_vec[$past(fill_frame)] && ref_vec[$past(fill_frame)]));
  assert_fill_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && (fill_frame <= LAST_IDX) && !(acc_valid && acc_write && acc_frame == fill_frame))
      |=> !dirty_vec[$past(fill_frame)]);

endmodule

bind clock_victim_sel clock_victim_chk #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(core_rst_n),
  .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
  .fill_valid(fill_valid), .fill_frame(fill_frame),
  .busy(busy), .done(done), .victim(victim),
  .victim_dirty(victim_dirty), .victim_free(victim_free),
  .hand(hand), .ref_vec(ref_vec), .dirty_vec(dirty_vec), .occ_vec(occ_vec)
);

// File: tb/tb_clock_victim_sel.sv
module tb_clock_victim_sel;
  localparam int N  = 6;
  localparam int IW = $clog2(N);

  logic          clk, rst_n;
  logic          acc_valid, acc_write, fill_valid, req;
  logic [IW-1:0] acc_frame, fill_frame;
  logic          busy, done, victim_dirty, victim_free;
  logic [IW-1:0] victim;

  int checks, fails;
  bit m_ref[N], m_dirty[N], m_occ[N];
  int m_hand;

  clock_victim_sel #(.NFRAMES(N)) dut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
    .fill_valid(fill_valid), .fill_frame(fill_frame),
    .req(req), .busy(busy), .done(done), .victim(victim),
    .victim_dirty(victim_dirty), .victim_free(victim_free)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_access(input int f, input bit w);
    @(negedge clk);
    acc_valid = 1'b1; acc_frame = IW'(f); acc_write = w;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    m_ref[f] = 1'b1;
    if (w) m_dirty[f] = 1'b1;
  endtask

  task automatic do_fill(input int f);
    @(negedge clk);
    fill_valid = 1'b1; fill_frame = IW'(f);
    @(negedge clk);
    fill_valid = 1'b0;
    m_occ[f] = 1'b1; m_ref[f] = 1'b1; m_dirty[f] = 1'b0;
  endtask

  // A hit_off of -1 means no access during the scan. Otherwise an access
  // lands on the frame that the scan examines at step hit_off.
  task automatic do_request(input int hit_off, output int got_v);
    int exp_v, exp_k, h0, h, cnt, hit_f;
    bit exp_d, exp_f, seen;
    exp_v = 0; exp_d = 0; exp_f = 0; exp_k = 0; h0 = m_hand; hit_f = -1;
    for (int i = N - 1; i >= 0; i--) if (!m_occ[i]) begin exp_v = i; exp_f = 1'b1; end
    if (exp_f) exp_k = 1;
    else begin
      h = m_hand;
      for (int s = 0; s <= N; s++) begin
        exp_k++;
        if (!m_ref[h]) begin
          exp_v = h; exp_d = m_dirty[h]; m_hand = (h + 1) % N;
          break;
        end
        m_ref[h] = 1'b0;
        h = (h + 1) % N;
      end
    end
    if (hit_off >= 0) begin
      hit_f = (h0 + hit_off) % N;
      m_ref[hit_f] = 1'b1;  // R10: the access wins over the scan clear
    end
    @(negedge clk);
    req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    cnt = 0; seen = 1'b0;
    if (hit_off == 0) begin acc_valid = 1'b1; acc_frame = IW'(hit_f); end
    for (int t = 0; t < 3 * N; t++) begin
      @(posedge clk);
      @(negedge clk);
      acc_valid = 1'b0;
      cnt++;
      if (done) begin seen = 1'b1; break; end
      chk(busy == 1'b1, "R11 busy during scan", int'(busy), 1);
      if (hit_off > 0 && cnt == hit_off) begin acc_valid = 1'b1; acc_frame = IW'(hit_f); end
    end
    chk(seen, "R11 done seen", int'(seen), 1);
    chk(int'(victim) == exp_v, exp_f ? "R2 free victim" : "R6 victim", int'(victim), exp_v);
    chk(victim_free == exp_f, "R2/R6 victim_free", int'(victim_free), int'(exp_f));
    chk(victim_dirty == exp_d, "R7 victim_dirty", int'(victim_dirty), int'(exp_d));
    chk(cnt == exp_k, "R5 scan cycles", cnt, exp_k);
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", int'(done), 0);
    chk(int'(victim) == exp_v, "R11 result held", int'(victim), exp_v);
    got_v = exp_v;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int v, v2, k;
    void'($urandom(32'd20240611));
    checks = 0; fails = 0; m_hand = 0;
    for (int i = 0; i < N; i++) begin m_ref[i] = 0; m_dirty[i] = 0; m_occ[i] = 0; end
    rst_n = 1'b0; req = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
    fill_valid = 1'b0; acc_frame = '0; fill_frame = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(done == 1'b0, "R1 done low", int'(done), 0);
    chk(busy == 1'b0, "R1 busy low", int'(busy), 0);
    do_request(-1, v);
    chk(v == 0, "R1 first victim free frame 0", v, 0);
    // R2: lowest free frame is chosen
    do_fill(0); do_fill(2);
    do_request(-1, v);
    chk(v == 1, "R2 lowest free", v, 1);
    // R4: filled frames become occupied, so the free scan moves past them
    for (int i = 0; i < N; i++) if (!m_occ[i]) do_fill(i);
    // R9: every reference bit set, so a full rotation returns the start frame
    do_request(-1, v);
    chk(v == 0, "R9 full rotation victim", v, 0);
    // R8: the hand moved to 1 and all reference bits are now clear
    do_request(-1, v2);
    chk(v2 == 1, "R8 hand advanced", v2, 1);
    // R3/R7: a write access sets dirty, and the victim reports it
    do_access(2, 1'b1); do_access(2, 1'b0);
    do_request(-1, v);
    chk(v == 3, "R5 skip referenced frame", v, 3);
    do_request(-1, v);
    chk(v == 4, "R5 next", v, 4);
    do_access(5, 1'b1); do_access(0, 1'b0); do_access(1, 1'b0);
    do_request(-1, v);
    chk(v == 2 && victim_dirty, "R7 dirty writeback", int'(victim_dirty), 1);
    // R4: a fill clears dirty
    do_access(3, 1'b1); do_fill(3);
    // R10: collision of an access with the scan clear
    for (int i = 0; i < N; i++) do_access(i, 1'b0);
    do_request(2, v);
    do_request(-1, v);
    // random traffic
    for (int it = 0; it < 400; it++) begin
      k = $urandom_range(4);
      for (int j = 0; j < k; j++) begin
        if ($urandom_range(3) == 0) do_fill($urandom_range(N - 1));
        else do_access($urandom_range(N - 1), 1'($urandom_range(1)));
      end
      do_request(-1, v);
      if ($urandom_range(1) == 1) do_fill(v);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule